// File: doc/BRIEF.md
# Monitor Setup Byte Stream Decoder

This block turns the byte stream of a monitor-mode setup write into register values for a channel scan controller. A serial slave front end hands it one byte at a time with a valid strobe, and it signals the start of each write transaction with a pulse. The block does not handle bus framing, address matching or conversion.

The first byte of a transaction is a control byte. It carries four per-channel alarm-clear requests, a 3-bit scan delay code and an interrupt enable. After it come threshold records of three bytes each. Each record holds a 12-bit lower limit and a 12-bit upper limit. Which channels expect a record depends on a 2-bit highest-channel select and a differential-mode input. In differential mode the odd channels are left out of the stream, and no filler bytes take their place. Each record then applies to an even/odd channel pair.

Every byte is acknowledged. A done flag rises once the last expected record is complete. It stays high, and any further bytes are ignored, until the next transaction starts.

Top module: `mon_setup_decoder`

## Requirements
- R1: The control byte loads `delay_code` from bits 3:1 and `int_enable` from bit 0. Both outputs are valid in the cycle after the byte is accepted.
- R2: Control byte bits 7, 6, 5 and 4 request an alarm clear for channels 0, 1, 2 and 3. In the cycle after the control byte, each set bit drives `alarm_clr[n]` high for exactly one cycle.
- R3: A record is packed as follows. Byte 1 holds lower limit bits 11:4. Byte 2 holds lower limit bits 3:0 in bits 7:4 and upper limit bits 11:8 in bits 3:0. Byte 3 holds upper limit bits 7:0. Channel n appears at `thr_lo[n*12 +: 12]` and `thr_hi[n*12 +: 12]`.
- R4: In single-ended mode (`diff_mode`=0), records are expected for channels 0 up to `chan_sel`, in ascending order.
- R5: In differential mode (`diff_mode`=1), records are expected for channel 0, and also for channel 2 when `chan_sel` is at least 2. Each record is written to both its even channel and the next odd channel.
- R6: Every accepted byte produces `byte_ack` high in the following cycle. `byte_ack` is low in any cycle that does not follow an accepted byte.
- R7: A channel's stored limits change only in the cycle after the third byte of its record. One or two bytes of a record have no effect on them.
- R8: `setup_done` rises in the cycle after the third byte of the last expected record. It then stays high until the next start pulse. Bytes received while done is high are acknowledged, but they change no output other than `byte_ack`.
- R9: A `start` pulse clears `setup_done` and makes the next byte the control byte. This discards any partly received record. A byte that arrives in the same cycle as `start` is taken as the control byte.
- R10: After reset the outputs take these values: lower limits 0x800, upper limits 0x7FF, `delay_code` 0, `int_enable` 0, `alarm_clr` 0, `byte_ack` 0 and `setup_done` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Transaction start pulse |
| byte_valid | input | 1 | A byte is present on `byte_data` |
| byte_data | input | 8 | Received byte |
| chan_sel | input | 2 | Highest channel to configure |
| diff_mode | input | 1 | 1 selects differential channel pairs |
| byte_ack | output | 1 | Acknowledge for the previous cycle's byte |
| setup_done | output | 1 | All expected records received |
| delay_code | output | 3 | Scan delay code |
| int_enable | output | 1 | Interrupt enable |
| alarm_clr | output | 4 | One-cycle alarm clear pulses, bit n for channel n |
| thr_lo | output | 48 | Lower limits, 12 bits per channel |
| thr_hi | output | 48 | Upper limits, 12 bits per channel |

## Verification
A wrong phase or byte index shows as limits landing in the wrong channel slot, or with their nibbles swapped. It shows in the cycle after the third byte of the affected record. A wrong next-channel decision shows as `setup_done` rising one record early or late, which is visible in the cycle after the byte that ends the record. A stale byte counter after a restart corrupts the first record of the new transaction, and the first limit comparison after the restart reveals it.

// File: rtl/mon_setup_decoder.sv
module mon_setup_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        byte_valid,
  input  logic [7:0]  byte_data,
  input  logic [1:0]  chan_sel,
  input  logic        diff_mode,
  output logic        byte_ack,
  output logic        setup_done,
  output logic [2:0]  delay_code,
  output logic        int_enable,
  output logic [3:0]  alarm_clr,
  output logic [47:0] thr_lo,
  output logic [47:0] thr_hi
);
  localparam int NCH = 4;
  localparam int TW  = 12;

  typedef enum logic [1:0] {PH_CTRL, PH_REC, PH_DONE} phase_t;

  phase_t           phase_q;
  logic [1:0]       ch_q;
  logic [1:0]       bidx_q;
  logic [7:0]       stage0_q, stage1_q;
  logic [NCH-1:0][TW-1:0] lo_q, hi_q;

  phase_t           phase_eff;
  logic [NCH-1:0]   active;
  logic [1:0]       nxt_ch;
  logic             has_next;

  assign phase_eff = start ? PH_CTRL : phase_q;

  assign active[0] = 1'b1;
  assign active[1] = (chan_sel >= 2'd1) && !diff_mode;
  assign active[2] = (chan_sel >= 2'd2);
  assign active[3] = (chan_sel == 2'd3) && !diff_mode;

  always_comb begin
    nxt_ch   = ch_q;
    has_next = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (i > int'(ch_q) && active[i]) begin
        nxt_ch   = 2'(i);
        has_next = 1'b1;
      end
    end
  end

  assign thr_lo = lo_q;
  assign thr_hi = hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_CTRL;
      ch_q       <= '0;
      bidx_q     <= '0;
      stage0_q   <= '0;
      stage1_q   <= '0;
      byte_ack   <= 1'b0;
      setup_done <= 1'b0;
      delay_code <= '0;
      int_enable <= 1'b0;
      alarm_clr  <= '0;
      for (int i = 0; i < NCH; i++) begin
        lo_q[i] <= 12'h800;
        hi_q[i] <= 12'h7FF;
      end
    end else begin
      byte_ack  <= byte_valid;
      alarm_clr <= '0;
      if (start) begin
        phase_q    <= PH_CTRL;
        setup_done <= 1'b0;
      end
      if (byte_valid) begin
        unique case (phase_eff)
          PH_CTRL: begin
            alarm_clr  <= {byte_data[4], byte_data[5], byte_data[6], byte_data[7]};
            delay_code <= byte_data[3:1];
            int_enable <= byte_data[0];
            phase_q    <= PH_REC;
            ch_q       <= '0;
            bidx_q     <= '0;
          end
          PH_REC: begin
            if (bidx_q == 2'd0) begin
              stage0_q <= byte_data;
              bidx_q   <= 2'd1;
            end else if (bidx_q == 2'd1) begin
              stage1_q <= byte_data;
              bidx_q   <= 2'd2;
            end else begin
              lo_q[ch_q] <= {stage0_q, stage1_q[7:4]};
              hi_q[ch_q] <= {stage1_q[3:0], byte_data};
              if (diff_mode) begin
                lo_q[ch_q | 2'd1] <= {stage0_q, stage1_q[7:4]};
                hi_q[ch_q | 2'd1] <= {stage1_q[3:0], byte_data};
              end
              bidx_q <= 2'd0;
              if (has_next) begin
                ch_q <= nxt_ch;
              end else begin
                phase_q    <= PH_DONE;
                setup_done <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module mon_setup_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        byte_valid,
  input logic        byte_ack,
  input logic        setup_done,
  input logic [2:0]  delay_code,
  input logic        int_enable,
  input logic [3:0]  alarm_clr,
  input logic [47:0] thr_lo,
  input logic [47:0] thr_hi
);
  assert_ack_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> byte_ack);
  assert_no_spurious_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid |=> !byte_ack);
  assert_clr_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid |=> alarm_clr == 4'd0);
  assert_thr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid |=> ($stable(thr_lo) && $stable(thr_hi)));
  assert_ctrl_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid |=> ($stable(delay_code) && $stable(int_enable)));
  assert_done_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !setup_done);
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_done && !start) |=> setup_done);
  assert_done_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_done && !start) |=> ($stable(thr_lo) && $stable(thr_hi)));
endmodule

bind mon_setup_decoder mon_setup_decoder_chk chk (.*);

// File: tb/mon_setup_decoder_test.sv
module mon_setup_decoder_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic        byte_valid = 0;
  logic [7:0]  byte_data = 0;
  logic [1:0]  chan_sel = 0;
  logic        diff_mode = 0;
  logic        byte_ack, setup_done, int_enable;
  logic [2:0]  delay_code;
  logic [3:0]  alarm_clr;
  logic [47:0] thr_lo, thr_hi;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [11:0] exp_lo [4];
  logic [11:0] exp_hi [4];

  always #2 clk = ~clk;

  mon_setup_decoder uut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] flat_lo();
    return {exp_lo[3], exp_lo[2], exp_lo[1], exp_lo[0]};
  endfunction
  function automatic logic [47:0] flat_hi();
    return {exp_hi[3], exp_hi[2], exp_hi[1], exp_hi[0]};
  endfunction

  task automatic check_thr(string req);
    check(req, {16'd0, thr_lo}, {16'd0, flat_lo()});
    check(req, {16'd0, thr_hi}, {16'd0, flat_hi()});
  endtask

  task automatic send_byte(logic [7:0] b);
    @(negedge clk);
    byte_valid = 1; byte_data = b;
    @(negedge clk);
    byte_valid = 0;
    check("R6 ack", {63'd0, byte_ack}, 64'd1);
  endtask

  task automatic begin_txn(logic [1:0] sel, logic dm);
    chan_sel = sel; diff_mode = dm;
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    check("R9 done cleared", {63'd0, setup_done}, 64'd0);
    check("R6 idle ack low", {63'd0, byte_ack}, 64'd0);
  endtask

  task automatic send_ctrl(logic [7:0] c);
    send_byte(c);
    check("R2 clear pulse", {60'd0, alarm_clr}, {60'd0, c[4], c[5], c[6], c[7]});
    check("R1 delay", {61'd0, delay_code}, {61'd0, c[3:1]});
    check("R1 int enable", {63'd0, int_enable}, {63'd0, c[0]});
    @(negedge clk);
    check("R2 pulse one cycle", {60'd0, alarm_clr}, 64'd0);
  endtask

  task automatic send_rec(int ch, logic dm, logic [11:0] lo, logic [11:0] hi, logic last);
    send_byte(lo[11:4]);
    check_thr("R7 after byte 1");
    send_byte({lo[3:0], hi[11:8]});
    check_thr("R7 after byte 2");
    check("R8 not done early", {63'd0, setup_done}, 64'd0);
    send_byte(hi[7:0]);
    exp_lo[ch] = lo; exp_hi[ch] = hi;
    if (dm) begin exp_lo[ch | 1] = lo; exp_hi[ch | 1] = hi; end
    check_thr("R3 R4 R5 record stored");
    check("R8 done", {63'd0, setup_done}, {63'd0, last});
  endtask

  task automatic t_reset();
    check_thr("R10 reset limits");
    check("R10 done", {63'd0, setup_done}, 64'd0);
    check("R10 ack", {63'd0, byte_ack}, 64'd0);
    check("R10 delay", {61'd0, delay_code}, 64'd0);
    check("R10 int", {63'd0, int_enable}, 64'd0);
    check("R10 clr", {60'd0, alarm_clr}, 64'd0);
  endtask

  task automatic t_single_all();
    begin_txn(2'd3, 0);
    send_ctrl(8'hA7);
    send_rec(0, 0, 12'h123, 12'hABC, 0);
    send_rec(1, 0, 12'h456, 12'hDEF, 0);
    send_rec(2, 0, 12'h789, 12'h135, 0);
    send_rec(3, 0, 12'h9F0, 12'h0F9, 1);
  endtask

  task automatic t_single_two_extra();
    begin_txn(2'd1, 0);
    send_ctrl(8'h5E);
    send_rec(0, 0, 12'h111, 12'h222, 0);
    send_rec(1, 0, 12'h333, 12'h444, 1);
    send_byte(8'hFF);
    send_byte(8'h00);
    send_byte(8'h5A);
    check_thr("R8 extra bytes ignored");
    check("R8 done held", {63'd0, setup_done}, 64'd1);
    check("R8 delay unchanged", {61'd0, delay_code}, 64'd7);
    check("R8 clr quiet", {60'd0, alarm_clr}, 64'd0);
  endtask

  task automatic t_sel0();
    begin_txn(2'd0, 0);
    send_ctrl(8'h10);
    send_rec(0, 0, 12'hFED, 12'h012, 1);
  endtask

  task automatic t_diff_full();
    begin_txn(2'd3, 1);
    send_ctrl(8'hF3);
    send_rec(0, 1, 12'h2A5, 12'h5A2, 0);
    send_rec(2, 1, 12'h3C6, 12'h6C3, 1);
  endtask

  task automatic t_diff_one();
    begin_txn(2'd1, 1);
    send_ctrl(8'h08);
    send_rec(0, 1, 12'h0AA, 12'hBB0, 1);
  endtask

  task automatic t_restart();
    begin_txn(2'd2, 0);
    send_ctrl(8'h02);
    send_byte(8'hEE);
    send_byte(8'hEE);
    check_thr("R7 partial record");
    begin_txn(2'd2, 0);
    send_ctrl(8'h04);
    send_rec(0, 0, 12'h314, 12'h159, 0);
    send_rec(1, 0, 12'h265, 12'h358, 0);
    send_rec(2, 0, 12'h979, 12'h323, 1);
  endtask

  task automatic t_start_with_byte();
    chan_sel = 2'd0; diff_mode = 0;
    @(negedge clk);
    start = 1; byte_valid = 1; byte_data = 8'h8D;
    @(negedge clk);
    start = 0; byte_valid = 0;
    check("R9 byte with start is control", {61'd0, delay_code}, 64'd6);
    check("R9 clr from same byte", {60'd0, alarm_clr}, 64'd1);
    check("R9 done cleared", {63'd0, setup_done}, 64'd0);
    send_rec(0, 0, 12'h800, 12'h7FF, 1);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin exp_lo[i] = 12'h800; exp_hi[i] = 12'h7FF; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single_all();
    t_single_two_extra();
    t_sel0();
    t_diff_full();
    t_diff_one();
    t_restart();
    t_start_with_byte();
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule